// File: doc/BRIEF.md
# Circular-Buffer Address Mask Unit

This block sits in the operand-address path of a multiply-accumulate unit that also moves data to or from memory. A software-visible mask register supplies the low half of a 32-bit mask whose upper half is fixed at all ones. When an access asks for masking, its operand address is ANDed with that mask. Clearing chosen mask bits therefore pins a pointer inside an aligned, power-of-two-sized region of memory.

A small file of address pointers is kept locally. An access names one pointer and may post-increment it by two or four bytes. The incremented value passes through the same mask before it is written back. As a result, a pointer that steps through a circular buffer wraps to the buffer start with no extra instructions.

Masking is selected per access. An access without the mask flag sees its pointer unchanged. The masked address is presented one cycle after the access is accepted.

Top module: `cbuf_mask_unit`

## Requirements
- R1: After reset the stored mask bits are all ones, so `maskRdData` reads 0xFFFFFFFF. `outVld` is 0, `outAddr` is 0, and every pointer reads 0.
- R2: A mask write stores only bits 15:0 of `maskWrData`. `maskRdData` always returns ones in bits 31:16 and the stored bits in 15:0.
- R3: An access with `accValid`=1 and `maskSel`=1 produces, on the next cycle, `outVld`=1 and `outAddr` = selected pointer AND {0xFFFF, stored mask}.
- R4: An access with `maskSel`=0 produces, on the next cycle, `outVld`=1 and `outAddr` equal to the selected pointer unchanged.
- R5: A mask write becomes visible on the cycle after it is presented. An access presented in the same cycle as a mask write uses the old mask.
- R6: With `postInc`=1, the selected pointer becomes pointer + 2 when `accSize`=0, or pointer + 4 when `accSize`=1. When `maskSel`=1, that sum is ANDed with the mask before write-back, so the pointer wraps inside the buffer. The emitted address is the value before the increment.
- R7: An access with `postInc`=0 leaves its pointer unchanged.
- R8: `ptrWrEn` loads `ptrWrData` into pointer `ptrWrIdx` on the next cycle. If a post-increment targets the same pointer in the same cycle, the load wins.
- R9: On a cycle with no access, `outVld` is 0 on the next cycle and `outAddr` holds its previous value.
- R10: `ptrRdData` shows the current content of pointer `ptrRdIdx` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| maskWrEn | input | 1 | Mask register write strobe |
| maskWrData | input | 32 | Mask write data (low 16 bits kept) |
| maskRdData | output | 32 | Mask read value, upper half all ones |
| ptrWrEn | input | 1 | Pointer load strobe |
| ptrWrIdx | input | 3 | Pointer to load |
| ptrWrData | input | 32 | Pointer load value |
| ptrRdIdx | input | 3 | Pointer to read |
| ptrRdData | output | 32 | Pointer read value |
| accValid | input | 1 | Operand access request |
| accIdx | input | 3 | Pointer used by the access |
| accSize | input | 1 | 0: two-byte step, 1: four-byte step |
| postInc | input | 1 | Post-increment the pointer |
| maskSel | input | 1 | Apply the mask to this access |
| outVld | output | 1 | Masked address valid |
| outAddr | output | 32 | Final operand address |

## Verification
Two pairs of functions can meet in one cycle. The first is a mask write with a masked access, where the access must use the old mask. The second is a pointer load with a post-increment of the same pointer, where the load must win. Directed steps force each collision. The random phase also produces them often, because it draws pointer indices from a small range and writes the mask frequently. A reference model in the bench predicts the result of each collision from the stated priorities. Every cycle it compares the emitted address, the mask read-back and the read-port pointer against that model.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int ADDR_W = 32;
  localparam int MASK_W = 16;
  localparam int STEP_W = 3;

  typedef struct packed {
    logic              maskLoad;
    logic              ptrLoad;
    logic              accFire;
    logic              applyMask;
    logic              incFire;
    logic [STEP_W-1:0] incBytes;
  } cbmStrobes_t;
endpackage

// File: rtl/cbm_ctrl.sv
module cbm_ctrl
  import cbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        maskWrEn,
  input  logic        ptrWrEn,
  input  logic        accValid,
  input  logic        accSize,
  input  logic        postInc,
  input  logic        maskSel,
  output cbmStrobes_t strobes,
  output logic        vldQ
);
  localparam logic [STEP_W-1:0] WORD_STEP = STEP_W'(2);
  localparam logic [STEP_W-1:0] LONG_STEP = STEP_W'(4);

  always_comb begin
    strobes           = '0;
    strobes.maskLoad  = maskWrEn;
    strobes.ptrLoad   = ptrWrEn;
    strobes.accFire   = accValid;
    strobes.applyMask = accValid & maskSel;
    strobes.incFire   = accValid & postInc;
    strobes.incBytes  = accSize ? LONG_STEP : WORD_STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vldQ <= 1'b0;
    else        vldQ <= accValid;
  end
endmodule

// File: rtl/cbm_datapath.sv
module cbm_datapath
  import cbm_pkg::*;
#(
  parameter int NUM_PTR = 8,
  localparam int IDX_W  = $clog2(NUM_PTR),
  localparam int HI_W   = ADDR_W - MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cbmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] maskWrData,
  input  logic [IDX_W-1:0]  ptrWrIdx,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic [IDX_W-1:0]  ptrRdIdx,
  input  logic [IDX_W-1:0]  accIdx,
  output logic [ADDR_W-1:0] maskRdData,
  output logic [ADDR_W-1:0] ptrRdData,
  output logic [ADDR_W-1:0] outAddr
);
  logic [MASK_W-1:0] maskQ;
  logic [ADDR_W-1:0] fullMask;
  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [ADDR_W-1:0] accPtr;
  logic [ADDR_W-1:0] incPtr;
  logic [ADDR_W-1:0] wbPtr;
  logic [ADDR_W-1:0] effAddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                maskQ <= '1;
    else if (strobes.maskLoad) maskQ <= maskWrData[MASK_W-1:0];
  end

  assign fullMask   = {{HI_W{1'b1}}, maskQ};
  assign maskRdData = fullMask;

  assign accPtr  = ptrQ[accIdx];
  assign incPtr  = accPtr + ADDR_W'(strobes.incBytes);
  assign wbPtr   = strobes.applyMask ? (incPtr & fullMask) : incPtr;
  assign effAddr = strobes.applyMask ? (accPtr & fullMask) : accPtr;

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic loadHit;
    logic incHit;
    assign loadHit = strobes.ptrLoad && (ptrWrIdx == IDX_W'(i));
    assign incHit  = strobes.incFire && (accIdx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptrQ[i] <= '0;
      else if (loadHit) ptrQ[i] <= ptrWrData;
      else if (incHit)  ptrQ[i] <= wbPtr;
    end
  end

  assign ptrRdData = ptrQ[ptrRdIdx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               outAddr <= '0;
    else if (strobes.accFire) outAddr <= effAddr;
  end
endmodule

// File: rtl/cbuf_mask_unit.sv
module cbuf_mask_unit
  import cbm_pkg::*;
#(
  parameter int NUM_PTR = 8,
  localparam int IDX_W  = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              maskWrEn,
  input  logic [ADDR_W-1:0] maskWrData,
  output logic [ADDR_W-1:0] maskRdData,
  input  logic              ptrWrEn,
  input  logic [IDX_W-1:0]  ptrWrIdx,
  input  logic [ADDR_W-1:0] ptrWrData,
  input  logic [IDX_W-1:0]  ptrRdIdx,
  output logic [ADDR_W-1:0] ptrRdData,
  input  logic              accValid,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic              accSize,
  input  logic              postInc,
  input  logic              maskSel,
  output logic              outVld,
  output logic [ADDR_W-1:0] outAddr
);
  cbmStrobes_t strobes;

  cbm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .maskWrEn(maskWrEn), .ptrWrEn(ptrWrEn),
    .accValid(accValid), .accSize(accSize), .postInc(postInc),
    .maskSel(maskSel), .strobes(strobes), .vldQ(outVld)
  );

  cbm_datapath #(.NUM_PTR(NUM_PTR)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .maskWrData(maskWrData),
    .ptrWrIdx(ptrWrIdx), .ptrWrData(ptrWrData), .ptrRdIdx(ptrRdIdx),
    .accIdx(accIdx), .maskRdData(maskRdData), .ptrRdData(ptrRdData),
    .outAddr(outAddr)
  );
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int NUM_PTR = 8,
  localparam int IDX_W  = $clog2(NUM_PTR)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              maskWrEn,
  input logic [31:0]       maskWrData,
  input logic [31:0]       maskRdData,
  input logic              ptrWrEn,
  input logic [IDX_W-1:0]  ptrWrIdx,
  input logic [31:0]       ptrWrData,
  input logic [IDX_W-1:0]  ptrRdIdx,
  input logic [31:0]       ptrRdData,
  input logic              accValid,
  input logic [IDX_W-1:0]  accIdx,
  input logic              accSize,
  input logic              postInc,
  input logic              maskSel,
  input logic              outVld,
  input logic [31:0]       outAddr
);
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    maskWrEn |=> maskRdData == {16'hFFFF, $past(maskWrData[15:0])}); // R2

  AST_OUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accValid |=> outVld); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accValid |=> !outVld && $stable(outAddr)); // R9

  AST_OLD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && maskSel |=>
      (outAddr & ~{16'hFFFF, $past(maskRdData[15:0])}) == 32'h0); // R5

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && !maskSel && (ptrRdIdx == accIdx) |=>
      outAddr == $past(ptrRdData)); // R4

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptrWrEn |=> (ptrRdIdx != $past(ptrWrIdx)) ||
                (ptrRdData == $past(ptrWrData))); // R8

  AST_NO_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ptrWrEn && (!accValid || !postInc) |=>
      (ptrRdIdx != $past(ptrRdIdx)) || $stable(ptrRdData)); // R7
endmodule

bind cbuf_mask_unit cbm_checker #(.NUM_PTR(NUM_PTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .maskWrEn(maskWrEn), .maskWrData(maskWrData),
  .maskRdData(maskRdData), .ptrWrEn(ptrWrEn), .ptrWrIdx(ptrWrIdx),
  .ptrWrData(ptrWrData), .ptrRdIdx(ptrRdIdx), .ptrRdData(ptrRdData),
  .accValid(accValid), .accIdx(accIdx), .accSize(accSize),
  .postInc(postInc), .maskSel(maskSel), .outVld(outVld), .outAddr(outAddr)
);

// File: tb/cbuf_mask_unit_bench.sv
module cbuf_mask_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic maskWrEn = 0;
  logic [31:0] maskWrData = 0;
  logic [31:0] maskRdData;
  logic ptrWrEn = 0;
  logic [IW-1:0] ptrWrIdx = 0;
  logic [31:0] ptrWrData = 0;
  logic [IW-1:0] ptrRdIdx = 0;
  logic [31:0] ptrRdData;
  logic accValid = 0;
  logic [IW-1:0] accIdx = 0;
  logic accSize = 0;
  logic postInc = 0;
  logic maskSel = 0;
  logic outVld;
  logic [31:0] outAddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] refMask;
  logic [31:0] refPtr [NP];
  logic [31:0] refOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbuf_mask_unit #(.NUM_PTR(NP)) u_cbuf_mask_unit (.*);

  function automatic logic [31:0] applyMask(logic [31:0] a, logic [15:0] m, logic en);
    return en ? (a & {16'hFFFF, m}) : a;
  endfunction

  function automatic logic [31:0] stepOf(logic sz);
    return sz ? 32'd4 : 32'd2;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    maskWrEn = 0; ptrWrEn = 0; accValid = 0; postInc = 0; maskSel = 0;
  endtask

  // Called just after a negedge with inputs already driven.
  task automatic step(string req);
    logic expVld;
    logic [31:0] cur;
    expVld = accValid;
    if (accValid) begin
      cur = refPtr[accIdx];
      refOut = applyMask(cur, refMask, maskSel);
      if (postInc) refPtr[accIdx] = applyMask(cur + stepOf(accSize), refMask, maskSel);
    end
    if (ptrWrEn) refPtr[ptrWrIdx] = ptrWrData;
    if (maskWrEn) refMask = maskWrData[15:0];
    @(posedge clk); #1;
    check({req, " R3/R4/R9 vld"}, {31'd0, outVld}, {31'd0, expVld});
    check({req, " R3/R4/R9 addr"}, outAddr, refOut);
    check({req, " R2 mask"}, maskRdData, {16'hFFFF, refMask});
    check({req, " R10 ptr"}, ptrRdData, refPtr[ptrRdIdx]);
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    refMask = 16'hFFFF;
    refOut = 0;
    for (int i = 0; i < NP; i++) refPtr[i] = 0;
    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    check("R1 mask", maskRdData, 32'hFFFF_FFFF);
    check("R1 vld", {31'd0, outVld}, 32'd0);
    check("R1 addr", outAddr, 32'd0);
    check("R1 ptr", ptrRdData, 32'd0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    // R2: upper bits of write data ignored
    maskWrEn = 1; maskWrData = 32'h1234_FEFF; step("R2 load");

    // R8: load pointer 3 near end of 256-byte buffer
    ptrWrEn = 1; ptrWrIdx = 3; ptrWrData = 32'h2000_10FC; ptrRdIdx = 3; step("R8 load");

    // R6: masked long post-increment wraps 0x200010FC -> 0x20001000
    accValid = 1; accIdx = 3; accSize = 1; postInc = 1; maskSel = 1; step("R6 wrap");
    check("R6 wrapped ptr", ptrRdData, 32'h2000_1000);
    check("R6 pre-inc addr", outAddr, 32'h2000_10FC);

    // R6 unmasked word increment does not wrap
    ptrWrEn = 1; ptrWrIdx = 3; ptrWrData = 32'h2000_10FE; step("R8 reload");
    accValid = 1; accIdx = 3; accSize = 0; postInc = 1; maskSel = 0; step("R6 nomask");
    check("R6 unmasked ptr", ptrRdData, 32'h2000_1100);

    // R7: no post-increment keeps pointer
    accValid = 1; accIdx = 3; postInc = 0; maskSel = 1; step("R7 hold");
    check("R7 ptr held", ptrRdData, 32'h2000_1100);

    // R5: mask write with access in same cycle uses old mask
    accValid = 1; accIdx = 3; maskSel = 1; maskWrEn = 1; maskWrData = 32'h0000_00FF; step("R5 same");
    check("R5 old mask addr", outAddr, 32'h2000_1000);
    accValid = 1; accIdx = 3; maskSel = 1; step("R5 next");
    check("R5 new mask addr", outAddr, 32'h2000_0000);

    // R8: load beats post-increment on same pointer
    accValid = 1; accIdx = 3; postInc = 1; accSize = 1; maskSel = 0;
    ptrWrEn = 1; ptrWrIdx = 3; ptrWrData = 32'hABCD_0010; step("R8 collide");
    check("R8 load wins", ptrRdData, 32'hABCD_0010);

    // R9: idle cycle holds address
    step("R9 idle");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      maskWrEn = ($urandom_range(9) == 0);
      case ($urandom_range(2))
        0: maskWrData = $urandom();
        1: maskWrData = {$urandom_range(65535), 16'hFF00 | 16'($urandom_range(255)) & 16'hFFF0};
        default: maskWrData = 32'hFFFF_FF3F;
      endcase
      ptrWrEn = ($urandom_range(6) == 0);
      ptrWrIdx = IW'($urandom_range(3));
      ptrWrData = $urandom();
      ptrRdIdx = IW'($urandom_range(3));
      accValid = ($urandom_range(4) != 0);
      accIdx = IW'($urandom_range(3));
      accSize = 1'($urandom_range(1));
      postInc = 1'($urandom_range(1));
      maskSel = ($urandom_range(3) != 0);
      step("rand R6/R8");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule